// File: doc/BRIEF.md
# Dynamic Shift and Rotate Unit

This block performs the shift, rotate and byte-rearrangement operations of a 32-bit integer datapath. It takes an operation code, a destination operand, a second operand and the current carry/test flag. It returns the new destination value and the new flag. The second operand is either the signed shift amount or a second data source. Decode, the register file and memory access belong to the neighbouring logic.

The unit samples its inputs on a clock edge where the valid strobe is high and registers the result and flag on that edge. A one-cycle done pulse marks that edge. When the strobe is low, the outputs hold their values.

The shift-by-register operations treat the amount as signed. A non-negative amount shifts left by its low five bits. A negative amount shifts right by 32 minus its low five bits. When those low bits are zero, a negative amount shifts right by the full width.

Top module: `shift_rotate_unit`

## Requirements
- R1: While reset is low, and after it is released until the first valid strobe, res_rn is 0, res_t is 0 and done is 0.
- R2: On a clock edge with op_valid high, res_rn and res_t take the new values and done is 1 for the following cycle only. On an edge with op_valid low, res_rn and res_t keep their values and done is 0.
- R3: Op code 0 is the arithmetic shift by register. If src_rm[31] is 0, the result is src_rn shifted left by src_rm[4:0]. If src_rm[31] is 1 and src_rm[4:0] is 0, every result bit equals src_rn[31]. In all other cases the result is src_rn shifted right arithmetically by 32 - src_rm[4:0].
- R4: Op code 1 is the logical shift by register. It behaves as R3, except that the right shift fills with zeros and a negative amount with zero low five bits gives 0.
- R5: Op codes 0, 1, 15, 16 and 17 leave the flag unchanged: res_t equals the sampled flag_in.
- R6: Op code 2 rotates left by one, and res_t and result bit 0 both equal the old bit 31. Op code 3 rotates right by one, and res_t and result bit 31 both equal the old bit 0.
- R7: Op code 4 shifts left by one with flag_in entering bit 0, and res_t equals the old bit 31. Op code 5 shifts right by one with flag_in entering bit 31, and res_t equals the old bit 0.
- R8: Op code 6 shifts left by one with a zero fill, and res_t equals the old bit 31. Op code 7 shifts right logically by one, and res_t equals the old bit 0. Op code 8 shifts right arithmetically by one, keeping bit 31, and res_t equals the old bit 0.
- R9: Op codes 9 to 14 shift by fixed distances with a zero fill: left 2 (9), right 2 (10), left 8 (11), right 8 (12), left 16 (13), right 16 (14). res_t equals flag_in for all of them.
- R10: Op code 15 exchanges bits [15:8] and [7:0] and keeps bits [31:16]. Op code 16 exchanges the two halfwords. Op code 17 gives {src_rm[15:0], src_rn[31:16]}.
- R11: Op codes 18 to 31 pass src_rn to res_rn and flag_in to res_t unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Asynchronous reset, active low |
| op_valid | input | 1 | Strobe that samples the operation |
| op_code | input | 5 | Operation selector, codes per requirements |
| src_rn | input | 32 | Destination operand, old value |
| src_rm | input | 32 | Shift amount or second source |
| flag_in | input | 1 | Current carry/test flag |
| res_rn | output | 32 | Registered destination result |
| res_t | output | 1 | Registered flag result |
| done | output | 1 | One-cycle pulse after a sampled operation |

## Verification
A wrong internal decision shows up at res_rn or res_t in the cycle right after the strobe, because nothing in the unit carries state across operations. The dynamic shifts need the most care. A mistake in the negative-amount arithmetic shows up as a result that is off by one bit position. A missed zero-low-bits case shows up as an unshifted operand where all-sign or zero was due. For this reason the random amounts are weighted toward negative values and toward values with zero low bits. A flag mux error affects only res_t, so every operation checks the flag together with the data.

// File: rtl/sru_pkg.sv
package sru_pkg;

  parameter int unsigned SRU_W   = 32;
  parameter int unsigned SRU_OPW = 5;
  localparam int unsigned SRU_SHW = $clog2(SRU_W);
  localparam int unsigned SRU_HW  = SRU_W / 2;
  localparam int unsigned SRU_NFIX = 3;

  typedef logic [SRU_W-1:0] word_t;

  typedef enum logic [SRU_OPW-1:0] {
    OP_SHD_A = 5'd0,
    OP_SHD_L = 5'd1,
    OP_ROL1  = 5'd2,
    OP_ROR1  = 5'd3,
    OP_RCL1  = 5'd4,
    OP_RCR1  = 5'd5,
    OP_SHL1  = 5'd6,
    OP_SHR1  = 5'd7,
    OP_SAR1  = 5'd8,
    OP_SHL2  = 5'd9,
    OP_SHR2  = 5'd10,
    OP_SHL8  = 5'd11,
    OP_SHR8  = 5'd12,
    OP_SHL16 = 5'd13,
    OP_SHR16 = 5'd14,
    OP_SWPB  = 5'd15,
    OP_SWPH  = 5'd16,
    OP_XTR   = 5'd17
  } op_e;

  typedef enum logic [2:0] {
    GRP_DYN, GRP_BIT, GRP_FIX, GRP_PERM, GRP_NONE
  } grp_e;

  // distance of fixed-shift slot i
  function automatic int unsigned fixed_dist(input int unsigned i);
    case (i)
      0: return 2;
      1: return 8;
      default: return 16;
    endcase
  endfunction

  // right-shift distance for a negative amount: full width minus low bits
  function automatic logic [SRU_SHW:0] neg_dist(input logic [SRU_SHW-1:0] lo);
    return {1'b0, ~lo} + {{SRU_SHW{1'b0}}, 1'b1};
  endfunction

  function automatic word_t dyn_shift(input word_t rn, input word_t rm, input logic arith);
    logic [SRU_SHW-1:0] lo;
    lo = rm[SRU_SHW-1:0];
    if (!rm[SRU_W-1])      return rn << lo;
    else if (lo == '0)     return arith ? {SRU_W{rn[SRU_W-1]}} : '0;
    else if (arith)        return word_t'($signed(rn) >>> neg_dist(lo));
    else                   return rn >> neg_dist(lo);
  endfunction

  function automatic word_t swap_bytes(input word_t v);
    return {v[SRU_W-1:SRU_HW], v[7:0], v[15:8]};
  endfunction

  function automatic word_t swap_halves(input word_t v);
    return {v[SRU_HW-1:0], v[SRU_W-1:SRU_HW]};
  endfunction

  function automatic word_t extract_mid(input word_t rn, input word_t rm);
    return {rm[SRU_HW-1:0], rn[SRU_W-1:SRU_HW]};
  endfunction

  function automatic grp_e group_of(input logic [SRU_OPW-1:0] op);
    if (op <= OP_SHD_L)      return GRP_DYN;
    else if (op <= OP_SAR1)  return GRP_BIT;
    else if (op <= OP_SHR16) return GRP_FIX;
    else if (op <= OP_XTR)   return GRP_PERM;
    else                     return GRP_NONE;
  endfunction

endpackage

// File: rtl/sru_dyn_shift.sv
module sru_dyn_shift
  import sru_pkg::*;
(
  input  word_t                 rn,
  input  logic                  amt_neg,
  input  logic [SRU_SHW-1:0]    amt_lo,
  input  logic                  arith,
  output word_t                 res,
  output logic                  neg_full
);
  word_t amt_word;

  always_comb begin
    amt_word = '0;
    amt_word[SRU_W-1] = amt_neg;
    amt_word[SRU_SHW-1:0] = amt_lo;
  end

  assign neg_full = amt_neg && (amt_lo == '0);
  assign res      = dyn_shift(rn, amt_word, arith);
endmodule

// File: rtl/sru_bit_rot.sv
module sru_bit_rot
  import sru_pkg::*;
(
  input  word_t                 rn,
  input  logic                  t_in,
  input  logic [SRU_OPW-1:0]    op,
  output word_t                 res,
  output logic                  t_out
);
  logic msb, lsb;

  assign msb = rn[SRU_W-1];
  assign lsb = rn[0];

  always_comb begin
    res   = rn;
    t_out = t_in;
    case (op)
      OP_ROL1: begin res = {rn[SRU_W-2:0], msb};          t_out = msb; end
      OP_ROR1: begin res = {lsb, rn[SRU_W-1:1]};          t_out = lsb; end
      OP_RCL1: begin res = {rn[SRU_W-2:0], t_in};         t_out = msb; end
      OP_RCR1: begin res = {t_in, rn[SRU_W-1:1]};         t_out = lsb; end
      OP_SHL1: begin res = {rn[SRU_W-2:0], 1'b0};         t_out = msb; end
      OP_SHR1: begin res = {1'b0, rn[SRU_W-1:1]};         t_out = lsb; end
      OP_SAR1: begin res = {msb, rn[SRU_W-1:1]};          t_out = lsb; end
      default: begin res = rn;                            t_out = t_in; end
    endcase
  end
endmodule

// File: rtl/sru_fixed_shift.sv
module sru_fixed_shift
  import sru_pkg::*;
(
  input  word_t       rn,
  input  logic [1:0]  slot,
  input  logic        to_right,
  output word_t       res
);
  word_t lft [SRU_NFIX];
  word_t rgt [SRU_NFIX];

  for (genvar gi = 0; gi < SRU_NFIX; gi++) begin : g_dist
    localparam int unsigned D = fixed_dist(gi);
    assign lft[gi] = rn << D;
    assign rgt[gi] = rn >> D;
  end

  always_comb begin
    res = '0;
    for (int i = 0; i < SRU_NFIX; i++) begin
      if (slot == i[1:0]) res = to_right ? rgt[i] : lft[i];
    end
  end
endmodule

// File: rtl/shift_rotate_unit.sv
module shift_rotate_unit
  import sru_pkg::*;
#(
  parameter int unsigned DATA_W = SRU_W,
  parameter int unsigned OP_W   = SRU_OPW
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              op_valid,
  input  logic [OP_W-1:0]   op_code,
  input  logic [DATA_W-1:0] src_rn,
  input  logic [DATA_W-1:0] src_rm,
  input  logic              flag_in,
  output logic [DATA_W-1:0] res_rn,
  output logic              res_t,
  output logic              done
);
  localparam int unsigned FIX_BASE = OP_SHL2;

  grp_e         grp;
  word_t        dyn_res, bit_res, fix_res, perm_res;
  logic         bit_t;
  logic         dyn_neg_full;
  logic [4:0]   fix_off;
  word_t        nxt_rn;
  logic         nxt_t;
  word_t        rn_q;
  logic         t_q, done_q;
  logic         unused_rm_mid;

  assign unused_rm_mid = ^src_rm[DATA_W-2:SRU_HW];
  assign grp           = group_of(op_code);

  sru_dyn_shift u_dyn (
    .rn       (src_rn),
    .amt_neg  (src_rm[DATA_W-1]),
    .amt_lo   (src_rm[SRU_SHW-1:0]),
    .arith    (op_code == OP_SHD_A),
    .res      (dyn_res),
    .neg_full (dyn_neg_full)
  );

  sru_bit_rot u_bit (
    .rn    (src_rn),
    .t_in  (flag_in),
    .op    (op_code),
    .res   (bit_res),
    .t_out (bit_t)
  );

  assign fix_off = op_code - 5'(FIX_BASE);

  sru_fixed_shift u_fix (
    .rn       (src_rn),
    .slot     (fix_off[2:1]),
    .to_right (fix_off[0]),
    .res      (fix_res)
  );

  always_comb begin
    case (op_code)
      OP_SWPB: perm_res = swap_bytes(src_rn);
      OP_SWPH: perm_res = swap_halves(src_rn);
      default: perm_res = extract_mid(src_rn, src_rm);
    endcase
  end

  always_comb begin
    nxt_t = flag_in;
    case (grp)
      GRP_DYN:  nxt_rn = dyn_res;
      GRP_BIT:  begin nxt_rn = bit_res; nxt_t = bit_t; end
      GRP_FIX:  nxt_rn = fix_res;
      GRP_PERM: nxt_rn = perm_res;
      default:  nxt_rn = src_rn;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rn_q   <= '0;
      t_q    <= 1'b0;
      done_q <= 1'b0;
    end else begin
      done_q <= op_valid;
      if (op_valid) begin
        rn_q <= nxt_rn;
        t_q  <= nxt_t;
      end
    end
  end

  assign res_rn = rn_q;
  assign res_t  = t_q;
  assign done   = done_q;
endmodule

// File: rtl/sru_checker.sv
module sru_checker
  import sru_pkg::*;
(
  input logic                clk,
  input logic                rst_n,
  input logic                op_valid,
  input logic [SRU_OPW-1:0]  op_code,
  input logic [SRU_W-1:0]    src_rn,
  input logic                flag_in,
  input logic [SRU_W-1:0]    res_rn,
  input logic                res_t,
  input logic                done,
  input logic                dyn_neg_full
);
  AST_DONE_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
    op_valid |=> done) else $error("done missing");  // R2
  AST_NO_DONE: assert property (@(posedge clk) disable iff (!rst_n)
    !op_valid |=> !done) else $error("spurious done");  // R2
  AST_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !op_valid |=> ($stable(res_rn) && $stable(res_t))) else $error("outputs moved");  // R2
  AST_LOGIC_NEG_FULL: assert property (@(posedge clk) disable iff (!rst_n)
    (op_valid && op_code == OP_SHD_L && dyn_neg_full) |=> res_rn == '0) else $error("neg full logical");  // R4
  AST_ARITH_NEG_FULL: assert property (@(posedge clk) disable iff (!rst_n)
    (op_valid && op_code == OP_SHD_A && dyn_neg_full) |=> res_rn == {SRU_W{$past(src_rn[SRU_W-1])}}) else $error("neg full arith");  // R3
  AST_FLAG_KEPT: assert property (@(posedge clk) disable iff (!rst_n)
    (op_valid && op_code inside {OP_SHD_A, OP_SHD_L, OP_SWPB, OP_SWPH, OP_XTR}) |=> res_t == $past(flag_in)) else $error("flag changed");  // R5
  AST_ROL_FLAG: assert property (@(posedge clk) disable iff (!rst_n)
    (op_valid && op_code == OP_ROL1) |=> (res_t == $past(src_rn[SRU_W-1]) && res_rn[0] == res_t)) else $error("rotate left");  // R6
  AST_RCL_FILL: assert property (@(posedge clk) disable iff (!rst_n)
    (op_valid && op_code == OP_RCL1) |=> res_rn[0] == $past(flag_in)) else $error("carry rotate fill");  // R7
  AST_SAR_SIGN: assert property (@(posedge clk) disable iff (!rst_n)
    (op_valid && op_code == OP_SAR1) |=> res_rn[SRU_W-1] == $past(src_rn[SRU_W-1])) else $error("sign lost");  // R8
  AST_FIX_FLAG: assert property (@(posedge clk) disable iff (!rst_n)
    (op_valid && op_code >= OP_SHL2 && op_code <= OP_SHR16) |=> res_t == $past(flag_in)) else $error("fixed flag");  // R9
  AST_SWPB_TOP: assert property (@(posedge clk) disable iff (!rst_n)
    (op_valid && op_code == OP_SWPB) |=> res_rn[SRU_W-1:SRU_HW] == $past(src_rn[SRU_W-1:SRU_HW])) else $error("swap top");  // R10
endmodule

bind shift_rotate_unit sru_checker u_sru_chk (
  .clk          (clk),
  .rst_n        (rst_n),
  .op_valid     (op_valid),
  .op_code      (op_code),
  .src_rn       (src_rn),
  .flag_in      (flag_in),
  .res_rn       (res_rn),
  .res_t        (res_t),
  .done         (done),
  .dyn_neg_full (dyn_neg_full)
);

// File: tb/shift_rotate_unit_tb.sv
module shift_rotate_unit_tb;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        op_valid = 1'b0;
  logic [4:0]  op_code = '0;
  logic [31:0] src_rn = '0;
  logic [31:0] src_rm = '0;
  logic        flag_in = 1'b0;
  logic [31:0] res_rn;
  logic        res_t;
  logic        done;

  int n_checks = 0;
  int n_errors = 0;
  bit finished = 0;

  always #4 clk = ~clk;

  shift_rotate_unit u_dut (
    .clk(clk), .rst_n(rst_n), .op_valid(op_valid), .op_code(op_code),
    .src_rn(src_rn), .src_rm(src_rm), .flag_in(flag_in),
    .res_rn(res_rn), .res_t(res_t), .done(done)
  );

  function automatic string tag_of(input logic [4:0] op);
    if (op == 0) return "R3";
    if (op == 1) return "R4";
    if (op <= 3) return "R6";
    if (op <= 5) return "R7";
    if (op <= 8) return "R8";
    if (op <= 14) return "R9";
    if (op <= 17) return "R10";
    return "R11";
  endfunction

  // bit-at-a-time model of every operation
  function automatic logic [32:0] model(input logic [4:0] op, input logic [31:0] a,
                                        input logic [31:0] b, input logic t);
    logic [31:0] v = a;
    logic        nt = t;
    int          n;
    case (op)
      0, 1: begin
        if (b[31] == 1'b0) begin
          for (int i = 0; i < int'(b[4:0]); i++) v = {v[30:0], 1'b0};
        end else begin
          n = (b[4:0] == 0) ? 32 : 32 - int'(b[4:0]);
          for (int i = 0; i < n; i++) v = {(op == 0) ? v[31] : 1'b0, v[31:1]};
        end
      end
      2: begin nt = a[31]; v = {a[30:0], a[31]}; end
      3: begin nt = a[0];  v = {a[0], a[31:1]}; end
      4: begin nt = a[31]; v = {a[30:0], t}; end
      5: begin nt = a[0];  v = {t, a[31:1]}; end
      6: begin nt = a[31]; v = {a[30:0], 1'b0}; end
      7: begin nt = a[0];  v = {1'b0, a[31:1]}; end
      8: begin nt = a[0];  v = {a[31], a[31:1]}; end
      9:  v = a * 4;
      10: v = a / 4;
      11: v = a * 256;
      12: v = a / 256;
      13: v = a * 65536;
      14: v = a / 65536;
      15: v = {a[31:16], a[7:0], a[15:8]};
      16: v = {a[15:0], a[31:16]};
      17: v = {b[15:0], a[31:16]};
      default: ;
    endcase
    return {nt, v};
  endfunction

  task automatic check(input string req, input string what, input logic [31:0] act, input logic [31:0] exp);
    n_checks++;
    if (act !== exp) begin
      n_errors++;
      $display("FAIL %s %s: actual=%h expected=%h", req, what, act, exp);
    end
  endtask

  // drive at negedge, sample at next negedge (one register after the edge)
  task automatic run_op(input logic [4:0] op, input logic [31:0] a, input logic [31:0] b, input logic t);
    logic [32:0] exp = model(op, a, b, t);
    string req = tag_of(op);
    @(negedge clk);
    op_code = op; src_rn = a; src_rm = b; flag_in = t; op_valid = 1'b1;
    @(negedge clk);
    op_valid = 1'b0;
    check(req, "rn", res_rn, exp[31:0]);
    if (op <= 1 || (op >= 15 && op <= 17)) check("R5", "t", {31'd0, res_t}, {31'd0, exp[32]});
    else check(req, "t", {31'd0, res_t}, {31'd0, exp[32]});
    check("R2", "done", {31'd0, done}, 32'd1);
  endtask

  initial begin
    logic [31:0] held;
    logic        held_t;
    void'($urandom(32'h1234_5eed));
    #3;
    check("R1", "rn in reset", res_rn, 32'd0);
    check("R1", "t in reset", {31'd0, res_t}, 32'd0);
    @(negedge clk); @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    check("R1", "rn after reset", res_rn, 32'd0);
    check("R1", "done after reset", {31'd0, done}, 32'd0);

    // directed corners
    run_op(0, 32'h8000_1234, 32'h8000_0000, 1'b0);   // R3 all sign
    run_op(0, 32'h7000_1234, 32'hFFFF_FFE0, 1'b1);   // R3 all sign, positive
    run_op(1, 32'hF000_1234, 32'h8000_0000, 1'b1);   // R4 zero
    run_op(0, 32'h8000_0001, 32'hFFFF_FFFF, 1'b0);   // R3 right by 1
    run_op(1, 32'h8000_0001, 32'hFFFF_FFE1, 1'b0);   // R4 right by 31
    run_op(0, 32'h0000_0003, 32'h0000_001F, 1'b1);   // R3 left by 31
    run_op(1, 32'hDEAD_BEEF, 32'h0000_0020, 1'b0);   // R4 low bits zero, no shift
    run_op(4, 32'h8000_0000, 32'h0, 1'b1);           // R7
    run_op(5, 32'h0000_0001, 32'h0, 1'b0);           // R7
    run_op(8, 32'h8000_0003, 32'h0, 1'b0);           // R8
    run_op(15, 32'h1122_3344, 32'h0, 1'b1);          // R10
    run_op(17, 32'hAAAA_5555, 32'h1234_ABCD, 1'b0);  // R10
    run_op(25, 32'h0BAD_F00D, 32'h0, 1'b1);          // R11

    // R2: hold and done drop with valid low while inputs change
    held = res_rn; held_t = res_t;
    @(negedge clk);
    op_code = 5'd16; src_rn = 32'hCAFE_0001; flag_in = ~held_t;
    @(negedge clk);
    check("R2", "hold rn", res_rn, held);
    check("R2", "hold t", {31'd0, res_t}, {31'd0, held_t});
    check("R2", "done low", {31'd0, done}, 32'd0);

    for (int k = 0; k < 600; k++) begin
      logic [31:0] b = $urandom;
      int sel = $urandom_range(0, 3);
      if (sel == 0) b = {1'b1, b[30:5], 5'd0};
      else if (sel == 1) b[31] = 1'b1;
      run_op(5'($urandom_range(0, 31)), $urandom, b, 1'($urandom));
    end
    finished = 1;
  end

  initial begin
    fork
      wait (finished);
      begin
        repeat (100000) @(posedge clk);
        n_checks++; n_errors++;
        $display("FAIL watchdog: actual=timeout expected=completion");
      end
    join_any
    $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
    $finish;
  end
endmodule